// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block times the marks and spaces on the output of a demodulating infrared receiver. The input line is active low: a low level is a mark (carrier present) and a high level is a space. Each time the line changes level, the block reports the interval that just finished as a one-cycle event. The event carries a level bit (1 for a mark, 0 for a space) and a duration in counter ticks. With the default prescaler of 64, one tick is one microsecond of a 64 MHz clock.

A single up-counter runs freely and is cleared only when a mark ends. The length of a space is therefore the counter value at the start of the next mark. The length of a mark is the counter value when the mark ends, minus the value captured when it began. A programmable idle timeout compares the counter with a setting. It produces a single pulse when the line has sat in the space state long enough, which marks the end of a transmission.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset, and in every cycle in which `enable` is low, `evtValid` and `toutPulse` stay low. While disabled, the counter and the capture register are held at zero. Line changes seen while disabled produce no events.
- R2: The raw input passes through a two-stage synchronizer. A level change driven before clock edge N produces its event on the outputs in the cycle that follows edge N+2. `evtValid` is high for exactly that one cycle per line change.
- R3: The start of a mark (input going from high to low) reports `evtLevel`=0. The reported `evtDur` is the counter value at that edge, and that value is kept as the capture.
- R4: The end of a mark (input going from low to high) reports `evtLevel`=1. The reported `evtDur` is the counter value at that edge minus the capture taken at the preceding start of mark.
- R5: The counter advances by one every `PRESCALE` clock cycles. At the end of each mark, both the counter and the prescaler restart from zero. After enable, counting starts as if a mark had ended one cycle before the first enabled edge.
- R6: The counter saturates at `CNT_MAX` and does not wrap. A mark that begins and ends while the counter is saturated reports a duration of 0.
- R7: `toutPulse` is a one-cycle pulse. It fires one cycle after the counter first equals `toutVal` while the synchronized line is high. It fires at most once per idle period and is re-armed by the next start of mark.
- R8: If the synchronized line is low while the counter equals `toutVal`, no timeout pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the capture logic; low holds it idle and clears the counter |
| rxInN | input | 1 | Raw receiver line, low = mark |
| toutVal | input | CNT_W | Idle timeout, in ticks |
| evtValid | output | 1 | One-cycle strobe for a completed interval |
| evtLevel | output | 1 | 1 = the interval was a mark, 0 = a space |
| evtDur | output | CNT_W | Interval length in ticks |
| toutPulse | output | 1 | One-cycle idle-timeout strobe |

## Verification
The bench drives line changes at known cycles and predicts each event's level, duration and arrival cycle from the tick arithmetic. A wrong synchronizer depth or a missing prescaler clear shows up as an off-by-one duration or a late event.

Several corner cases get their own directed tests:
- Saturation is tested with long spaces and marks. A wrapping counter would report a small space and a large mark where a zero-length mark is expected.
- The timeout is tested both while the line is low, where it must stay silent, and in the following idle period, where it must fire exactly once at a predicted cycle. A design that ignored the line level or never re-armed would fail one of these two.
- Toggling the line while disabled catches a block that leaks events or keeps counting while off.

Random hold lengths mix one-cycle glitches with intervals longer than the saturation point.

// File: rtl/ir_capture_pkg.sv
package ir_capture_pkg;

  // Strobes handed from the control section to the datapath each cycle.
  typedef struct packed {
    logic run;        // capture logic enabled
    logic markStart;  // line fell: a mark begins, a space ends
    logic markEnd;    // line rose: a mark ends, counter restarts
  } capStrobes_t;

endpackage

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
  import ir_capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rxInN,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] toutVal,
  output capStrobes_t      strobes,
  output logic             lineLevel,
  output logic             toutPulse
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineQ;
  logic                   armed;
  logic                   toutHit;

  // Synchronizer chain; idle line is high, so reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '1;
      lineQ <= 1'b1;
    end else begin
      syncQ[0] <= rxInN;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        syncQ[i] <= syncQ[i-1];
      end
      lineQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lineLevel = syncQ[SYNC_STAGES-1];

  always_comb begin
    strobes.run       = enable;
    strobes.markStart = enable & lineQ & ~lineLevel;
    strobes.markEnd   = enable & ~lineQ & lineLevel;
  end

  // Timeout only counts while the line is idle high, once per idle period.
  assign toutHit = enable & armed & lineLevel & (count == toutVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      toutPulse <= 1'b0;
    end else begin
      toutPulse <= toutHit;
      if (!enable || strobes.markStart) begin
        armed <= 1'b1;
      end else if (toutHit) begin
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ir_capture_dp.sv
module ir_capture_dp
  import ir_capture_pkg::*;
#(
  parameter int              PRESCALE = 64,
  parameter int              CNT_W    = 32,
  parameter longint unsigned CNT_MAX  = 64'h7FFF_FFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  capStrobes_t      strobes,
  output logic [CNT_W-1:0] count,
  output logic             evtValid,
  output logic             evtLevel,
  output logic [CNT_W-1:0] evtDur
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic             tick;
  logic [CNT_W-1:0] capReg;

  // Tick generator: a divider when PRESCALE > 1, every cycle otherwise.
  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] preCnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          preCnt <= '0;
        end else if (!strobes.run || strobes.markEnd || preCnt == PRE_LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign tick = strobes.run & (preCnt == PRE_LAST);
    end else begin : g_nodiv
      assign tick = strobes.run;
    end
  endgenerate

  // Interval counter: cleared at mark end, saturating at the top value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!strobes.run || strobes.markEnd) begin
      count <= '0;
    end else if (tick && count != CNT_TOP) begin
      count <= count + 1'b1;
    end
  end

  // Capture of the counter at each mark start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capReg <= '0;
    end else if (!strobes.run) begin
      capReg <= '0;
    end else if (strobes.markStart) begin
      capReg <= count;
    end
  end

  // Event register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtValid <= 1'b0;
      evtLevel <= 1'b0;
      evtDur   <= '0;
    end else begin
      evtValid <= strobes.markStart | strobes.markEnd;
      evtLevel <= strobes.markEnd;
      if (strobes.markEnd) begin
        evtDur <= count - capReg;
      end else if (strobes.markStart) begin
        evtDur <= count;
      end else begin
        evtDur <= '0;
      end
    end
  end

endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
  import ir_capture_pkg::*;
#(
  parameter int              PRESCALE    = 64,
  parameter int              CNT_W       = 32,
  parameter longint unsigned CNT_MAX     = 64'h7FFF_FFFE,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rxInN,
  input  logic [CNT_W-1:0] toutVal,
  output logic             evtValid,
  output logic             evtLevel,
  output logic [CNT_W-1:0] evtDur,
  output logic             toutPulse
);

  capStrobes_t      strobes;
  logic [CNT_W-1:0] count;
  logic             lineLevel;

  ir_capture_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rxInN    (rxInN),
    .count    (count),
    .toutVal  (toutVal),
    .strobes  (strobes),
    .lineLevel(lineLevel),
    .toutPulse(toutPulse)
  );

  ir_capture_dp #(
    .PRESCALE(PRESCALE),
    .CNT_W   (CNT_W),
    .CNT_MAX (CNT_MAX)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .count   (count),
    .evtValid(evtValid),
    .evtLevel(evtLevel),
    .evtDur  (evtDur)
  );

endmodule

// File: rtl/ir_capture_rx_chk.sv
module ir_capture_rx_chk #(
  parameter int              CNT_W   = 32,
  parameter longint unsigned CNT_MAX = 64'h7FFF_FFFE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             evtValid,
  input logic             evtLevel,
  input logic [CNT_W-1:0] evtDur,
  input logic             toutPulse,
  input logic             lineLevel,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!evtValid && !toutPulse));

  p_space_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && !evtLevel) |-> !$past(lineLevel));

  p_mark_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtLevel) |-> $past(lineLevel));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_TOP);

  p_dur_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |-> (evtDur <= CNT_TOP));

  p_tout_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    toutPulse |=> !toutPulse);

  p_tout_idle_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    toutPulse |-> $past(lineLevel));

endmodule

bind ir_capture_rx ir_capture_rx_chk #(
  .CNT_W  (CNT_W),
  .CNT_MAX(CNT_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .evtValid (evtValid),
  .evtLevel (evtLevel),
  .evtDur   (evtDur),
  .toutPulse(toutPulse),
  .lineLevel(lineLevel),
  .count    (count)
);

// File: tb/ir_capture_rx_tb.sv
module ir_capture_rx_tb;

  localparam int P    = 4;
  localparam int W    = 16;
  localparam int CMAX = 100;

  logic         clk     = 1'b0;
  logic         rst_n   = 1'b0;
  logic         enable  = 1'b0;
  logic         rxInN   = 1'b1;
  logic [W-1:0] toutVal = 16'd200;
  logic         evtValid, evtLevel, toutPulse;
  logic [W-1:0] evtDur;

  ir_capture_rx #(
    .PRESCALE(P),
    .CNT_W   (W),
    .CNT_MAX (CMAX)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rxInN    (rxInN),
    .toutVal  (toutVal),
    .evtValid (evtValid),
    .evtLevel (evtLevel),
    .evtDur   (evtDur),
    .toutPulse(toutPulse)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit lvl;
    int dur;
    int at;
  } expEvt_t;

  expEvt_t expQ[$];
  int  nChecks = 0, nFail = 0;
  int  origin = 0, capExp = 0, lastRiseA = 0;
  int  toutCount = 0, lastToutCyc = 0, evtSeen = 0, lastDur = 0;
  bit  done = 1'b0;

  // Tick count the design should hold just before posedge a (R5, R6).
  function automatic int sampled(int a);
    int v;
    v = (a - 1 - origin) / P;
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive the line and queue the predicted event (R2, R3, R4).
  task automatic setLine(bit lvl, int hold);
    int a;
    int v;
    @(negedge clk);
    if (enable && lvl != rxInN) begin
      a = cyc + 3;
      v = sampled(a);
      if (!lvl) begin
        expQ.push_back('{lvl: 1'b0, dur: v, at: a});
        capExp = v;
      end else begin
        expQ.push_back('{lvl: 1'b1, dur: v - capExp, at: a});
        origin    = a;
        lastRiseA = a;
      end
    end
    rxInN = lvl;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic enableOn();
    @(negedge clk);
    enable = 1'b1;
    origin = cyc;
    capExp = 0;
  endtask

  // Output monitor.
  always @(negedge clk) begin
    expEvt_t e;
    if (rst_n && evtValid) begin
      evtSeen++;
      lastDur = int'(evtDur);
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected event duration", int'(evtDur), -1);
      end else begin
        e = expQ.pop_front();
        check(evtLevel == e.lvl, e.lvl ? "R4" : "R3", "event level", int'(evtLevel), int'(e.lvl));
        check(int'(evtDur) == e.dur, e.lvl ? "R4" : "R3", "event duration", int'(evtDur), e.dur);
        check(cyc == e.at, "R2", "event cycle", cyc, e.at);
      end
    end
    if (rst_n && toutPulse) begin
      toutCount++;
      lastToutCyc = cyc;
    end
  end

  initial begin
    #1_400_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int hold;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(evtValid == 1'b0, "R1", "evtValid after reset", int'(evtValid), 0);
    check(toutPulse == 1'b0, "R1", "toutPulse after reset", int'(toutPulse), 0);
    check(evtDur == '0, "R1", "evtDur after reset", int'(evtDur), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    enableOn();

    // Basic mark and space
    setLine(1'b1, 5);
    setLine(1'b0, 20);
    setLine(1'b1, 30);

    // R5: space of 9 cycles after a rise reads (9-1)/P = 2 ticks
    setLine(1'b0, 10);
    setLine(1'b1, 9);
    setLine(1'b0, 13);
    check(lastDur == 2, "R5", "space after prescaled count", lastDur, 2);
    setLine(1'b1, 20);

    // R7: timeout fires once, T*P+1 cycles after the rise is acted on
    setLine(1'b0, 4);
    toutVal   = 16'd5;
    toutCount = 0;
    repeat (8) @(negedge clk);
    setLine(1'b1, 80);
    check(toutCount == 1, "R7", "timeout pulse count", toutCount, 1);
    check(lastToutCyc == lastRiseA + 5 * P + 1, "R7", "timeout cycle", lastToutCyc, lastRiseA + 5 * P + 1);

    // R8: counter meets the setting while the line is low, so no pulse
    toutVal = 16'd3;
    setLine(1'b0, 10);
    toutCount = 0;
    setLine(1'b1, 6);
    setLine(1'b0, 40);
    check(toutCount == 0, "R8", "timeout during mark", toutCount, 0);
    setLine(1'b1, 40);
    check(toutCount == 1, "R8", "timeout re-armed after mark", toutCount, 1);
    check(lastToutCyc == lastRiseA + 3 * P + 1, "R7", "re-armed timeout cycle", lastToutCyc, lastRiseA + 3 * P + 1);

    // R6: saturation on long space and long mark
    toutVal = 16'd200;
    repeat (450) @(negedge clk);
    setLine(1'b0, 300);
    check(lastDur == CMAX, "R6", "saturated space", lastDur, CMAX);
    setLine(1'b1, 20);
    check(lastDur == 0, "R6", "mark within saturation", lastDur, 0);

    // R1: disabled, line activity ignored
    @(negedge clk);
    enable    = 1'b0;
    evtSeen   = 0;
    toutCount = 0;
    toutVal   = 16'd0;
    repeat (4) @(negedge clk);
    rxInN = 1'b0;
    repeat (6) @(negedge clk);
    rxInN = 1'b1;
    repeat (3) @(negedge clk);
    rxInN = 1'b0;
    repeat (5) @(negedge clk);
    rxInN = 1'b1;
    repeat (8) @(negedge clk);
    check(evtSeen == 0, "R1", "events while disabled", evtSeen, 0);
    check(toutCount == 0, "R1", "timeouts while disabled", toutCount, 0);
    toutVal = 16'd200;
    enableOn();
    setLine(1'b0, 15);
    setLine(1'b1, 15);

    // Random hold lengths
    toutCount = 0;
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) == 0) hold = int'($urandom_range(100, 500));
      else hold = int'($urandom_range(1, 30));
      setLine((i % 2) == 0 ? 1'b0 : 1'b1, hold);
    end
    setLine(1'b1, 10);
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2", "events still missing", expQ.size(), 0);
    check(toutCount == 0, "R7", "timeouts with unreachable setting", toutCount, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule